// File: doc/BRIEF.md
# Programmable-Rate Asynchronous Serial Port

This block is a full-duplex asynchronous serial transmitter and receiver that runs from the peripheral clock. A 16-bit divisor sets the rate of a 16x oversampling strobe. The serial bit rate can therefore be set anywhere from one sixteenth of the peripheral clock down to one part in 1,048,576 of it. The character shape is set by software: 5 to 8 data bits, an optional even or odd parity bit, and one or two stop bits. An external capture timer can measure an incoming rate and write the result into the divisor.

Software reaches the block through a small register bus. The registers are the divisor, line control, a status word, an interrupt mask, and the transmit and receive holding registers. Each direction has one holding register. Transmit and receive each raise their own maskable interrupt. Each direction also has a request/acknowledge pair for a DMA channel.

The transmitter follows a five-state machine: TX_IDLE, TX_START, TX_DATA, TX_PAR and TX_STOP. Each state except TX_IDLE lasts one bit, which is 16 strobes.
- TX_IDLE moves to TX_START on a strobe when the holding register is full.
- TX_START moves to TX_DATA.
- TX_DATA moves to TX_PAR or TX_STOP after the last data bit.
- TX_PAR moves to TX_STOP.
- TX_STOP moves straight to TX_START if another character is waiting. Otherwise it returns to TX_IDLE.

The receiver follows RX_IDLE, RX_START, RX_DATA, RX_PAR and RX_STOP.
- RX_IDLE moves to RX_START on a strobe that sees the line low.
- RX_START moves to RX_DATA only if the line is still low eight strobes later. Otherwise it falls back to RX_IDLE.
- RX_DATA samples one bit every 16 strobes, then moves to RX_PAR or RX_STOP.
- RX_STOP samples the first stop bit, posts the character and returns to RX_IDLE.

Top module: `sio_port`

Register map (3-bit address):

| Address | Register | Access |
|---|---|---|
| 0 | Divisor | read/write |
| 1 | Line control | read/write |
| 2 | Status | read; write 1 to clear the error bits |
| 3 | Interrupt mask | read/write |
| 4 | Transmit holding register | write |
| 5 | Receive holding register | read (the read empties it) |

## Requirements
- R1: After reset the following hold:
  - tx_o is high.
  - irq_o, txd_req and rxd_req are low.
  - Status (address 2) reads 0x0001.
  - The divisor register holds 1.
- R2: Writing address 0 sets the divisor D and restarts the strobe counter. The strobe period is D clocks, and a value of 0 means 65,536 clocks. Each serial bit lasts 16 strobes. With D=0, the first character written right after the divisor starts its start bit 65,536 clocks after the divisor write, and that bit then stays low for 1,048,576 clocks.
- R3: Line control (address 1) is laid out as follows:
  - bits[1:0]: data bits minus 5.
  - bit 2: parity enable.
  - bit 3: odd parity.
  - bit 4: two stop bits.
  - bit 5: transmit DMA enable.

  A character written to address 4 leaves tx_o as one low start bit, then the data bits LSB first, then the parity bit if enabled, then the stop bits (high). The line idles high.
- R4: The parity bit makes the count of ones over data plus parity even when bit 3 is 0, and odd when bit 3 is 1.
- R5: The frame length (data + parity + stop bits) is held to at least 7. Five data bits with no parity and one stop bit are sent with two stop bits. A character waiting in the holding register starts immediately after the last stop bit, with no idle gap.
- R6: The receiver samples each bit at the eighth strobe of the bit. A complete character is right-aligned, and reading address 5 returns it. Status bit 1 (receive full) is set while the character is unread. The read of address 5 clears it.
- R7: A low pulse on rx_i that is high again at mid-bit is rejected. No character is posted and no error is set.
- R8: A received parity bit that does not match the configured parity sets status bit 3.
- R9: A low first stop bit sets status bit 2.
- R10: If a character completes while the receive register is still full, status bit 4 is set and the stored character is kept.
- R11: Status bits 2, 3 and 4 stay set until a status write with a 1 in that bit position. Reading does not clear them.
- R12: irq_o is high when either of these holds:
  - mask bit 0 is set and the transmit holding register is empty;
  - mask bit 1 is set and the receive register is full or any error bit is set.

  With mask 0, irq_o stays low.
- R13: txd_req is high while line-control bit 5 is set, the transmit holding register is empty and no acknowledge has been seen since it emptied. A txd_ack pulse drops it on the next cycle.
- R14: rxd_req is high while the receive register is full and no acknowledge has been seen since it filled. An rxd_ack pulse drops it on the next cycle. It rises again for the next received character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (empties the receive register at address 5) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from bus_addr |
| rx_i | input | 1 | Serial receive line |
| tx_o | output | 1 | Serial transmit line |
| irq_o | output | 1 | Combined masked interrupt |
| txd_req | output | 1 | Transmit DMA request |
| txd_ack | input | 1 | Transmit DMA acknowledge pulse |
| rxd_req | output | 1 | Receive DMA request |
| rxd_ack | input | 1 | Receive DMA acknowledge pulse |

## Verification
The hardest condition to reach is a second character arriving exactly at the end of a stop bit. The bench reaches it by starting a clock-by-clock waveform checker in parallel with a status-polling writer. The writer loads the next character while the first is still shifting out, so the checker sees both frames run into each other at the clamped stop length.

The divisor-zero rate is another hard case, because its bit lasts over a million clocks. The bench checks it only through the start-bit edge and a mid-window sample. Receiver glitch and framing cases are driven as hand-built line waveforms whose widths are chosen around the mid-bit sampling point.

// File: rtl/sio_pkg.sv
package sio_pkg;
    localparam int OSR   = 16;
    localparam int OSR_W = $clog2(OSR);
    localparam int DMAX  = 8;

    localparam logic [2:0] A_DIV  = 3'd0;
    localparam logic [2:0] A_LINE = 3'd1;
    localparam logic [2:0] A_STAT = 3'd2;
    localparam logic [2:0] A_MASK = 3'd3;
    localparam logic [2:0] A_TXD  = 3'd4;
    localparam logic [2:0] A_RXD  = 3'd5;

    typedef enum logic [2:0] {TX_IDLE, TX_START, TX_DATA, TX_PAR, TX_STOP} tx_state_t;
    typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP} rx_state_t;

    typedef struct packed {
        logic [3:0] nbits;
        logic       par_en;
        logic       par_odd;
        logic [1:0] nstop;
    } frame_cfg_t;

    // Frame length below 7 (only 5 data, no parity, 1 stop) gets a second stop bit.
    function automatic frame_cfg_t decode_line(input logic [4:0] f);
        frame_cfg_t c;
        c.nbits   = 4'd5 + {2'b00, f[1:0]};
        c.par_en  = f[2];
        c.par_odd = f[3];
        c.nstop   = (f[4] || (f[1:0] == 2'b00 && !f[2])) ? 2'd2 : 2'd1;
        return c;
    endfunction
endpackage

// File: rtl/sio_tick.sv
module sio_tick #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam int CW = DIV_W + 1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] last;

    always_comb begin
        last = (div == '0) ? {1'b0, {DIV_W{1'b1}}} : CW'(div) - CW'(1);
        tick = (cnt == last);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt <= '0;
        else if (restart || tick) cnt <= '0;
        else                     cnt <= cnt + CW'(1);
    end
endmodule

// File: rtl/sio_tx.sv
module sio_tx
    import sio_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  frame_cfg_t      cfg,
    input  logic            thr_full,
    input  logic [DMAX-1:0] thr_data,
    output logic            take,
    output logic            busy,
    output logic            tx
);
    tx_state_t       st, nxt;
    logic [OSR_W-1:0] sub;
    logic [3:0]       idx;
    logic [DMAX-1:0]  shift;
    logic             par;
    logic             bit_end;
    logic [DMAX-1:0]  masked;

    always_comb begin
        bit_end = tick && (sub == OSR_W'(OSR - 1));
        masked  = thr_data & DMAX'((9'd1 << cfg.nbits) - 9'd1);
        nxt     = st;
        take    = 1'b0;
        unique case (st)
            TX_IDLE:  if (tick && thr_full) begin nxt = TX_START; take = 1'b1; end
            TX_START: if (bit_end) nxt = TX_DATA;
            TX_DATA:  if (bit_end && idx == cfg.nbits - 4'd1) nxt = cfg.par_en ? TX_PAR : TX_STOP;
            TX_PAR:   if (bit_end) nxt = TX_STOP;
            TX_STOP:  if (bit_end && idx == {2'b00, cfg.nstop} - 4'd1) begin
                          if (thr_full) begin nxt = TX_START; take = 1'b1; end
                          else nxt = TX_IDLE;
                      end
            default:  nxt = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st    <= TX_IDLE;
            sub   <= '0;
            idx   <= '0;
            shift <= '0;
            par   <= 1'b0;
        end else begin
            st <= nxt;
            if (tick) sub <= (st == TX_IDLE || bit_end) ? '0 : sub + 1'b1;
            if (bit_end) idx <= (nxt != st) ? 4'd0 : idx + 4'd1;
            if (take) begin
                shift <= masked;
                par   <= (^masked) ^ cfg.par_odd;
            end else if (st == TX_DATA && bit_end) begin
                shift <= shift >> 1;
            end
        end
    end

    always_comb begin
        busy = (st != TX_IDLE);
        unique case (st)
            TX_START: tx = 1'b0;
            TX_DATA:  tx = shift[0];
            TX_PAR:   tx = par;
            default:  tx = 1'b1;
        endcase
    end
endmodule

// File: rtl/sio_rx.sv
module sio_rx
    import sio_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  frame_cfg_t      cfg,
    input  logic            rx_in,
    output logic            done,
    output logic [DMAX-1:0] data,
    output logic            ferr,
    output logic            perr
);
    rx_state_t        st, nxt;
    logic [1:0]       sync;
    logic             rxs;
    logic [OSR_W-1:0] sub;
    logic [3:0]       idx;
    logic [DMAX-1:0]  shift;
    logic             pbit;
    logic             samp;

    always_comb begin
        rxs  = sync[1];
        samp = tick && ((st == RX_START) ? (sub == OSR_W'(OSR / 2 - 1))
                                         : (sub == OSR_W'(OSR - 1)));
        nxt  = st;
        unique case (st)
            RX_IDLE:  if (tick && !rxs) nxt = RX_START;
            RX_START: if (samp) nxt = rxs ? RX_IDLE : RX_DATA;
            RX_DATA:  if (samp && idx == cfg.nbits - 4'd1) nxt = cfg.par_en ? RX_PAR : RX_STOP;
            RX_PAR:   if (samp) nxt = RX_STOP;
            RX_STOP:  if (samp) nxt = RX_IDLE;
            default:  nxt = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync  <= 2'b11;
            st    <= RX_IDLE;
            sub   <= '0;
            idx   <= '0;
            shift <= '0;
            pbit  <= 1'b0;
        end else begin
            sync <= {sync[0], rx_in};
            st   <= nxt;
            if (tick) sub <= (st == RX_IDLE || samp) ? '0 : sub + 1'b1;
            if (samp) idx <= (nxt != st) ? 4'd0 : idx + 4'd1;
            if (st == RX_DATA && samp) shift <= {rxs, shift[DMAX-1:1]};
            if (st == RX_PAR && samp)  pbit  <= rxs;
        end
    end

    always_comb begin
        done = (st == RX_STOP) && samp;
        data = shift >> (4'(DMAX) - cfg.nbits);
        ferr = !rxs;
        perr = cfg.par_en && (pbit != ((^data) ^ cfg.par_odd));
    end
endmodule

// File: rtl/sio_port.sv
module sio_port
    import sio_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [2:0]  bus_addr,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    input  logic        rx_i,
    output logic        tx_o,
    output logic        irq_o,
    output logic        txd_req,
    input  logic        txd_ack,
    output logic        rxd_req,
    input  logic        rxd_ack
);
    logic [DIV_W-1:0] div_q;
    logic [5:0]       line_q;
    logic [1:0]       mask_q;
    logic [DMAX-1:0]  thr_q, rbr_q;
    logic             thr_full, rx_full;
    logic             ferr_q, perr_q, ovr_q;
    logic             tx_ack_seen, rx_ack_seen;
    frame_cfg_t       cfg;
    logic             tick, take, tx_busy;
    logic             rx_done, rx_ferr, rx_perr;
    logic [DMAX-1:0]  rx_data;
    logic             wr_div, wr_stat, wr_txd, pop, load;

    always_comb begin
        cfg     = decode_line(line_q[4:0]);
        wr_div  = bus_wr && bus_addr == A_DIV;
        wr_stat = bus_wr && bus_addr == A_STAT;
        wr_txd  = bus_wr && bus_addr == A_TXD && !thr_full;
        pop     = bus_rd && bus_addr == A_RXD;
        load    = rx_done && (!rx_full || pop);
    end

    sio_tick #(.DIV_W(DIV_W)) tick_i (
        .clk(clk), .rst_n(rst_n), .restart(wr_div), .div(div_q), .tick(tick)
    );

    sio_tx tx_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cfg(cfg), .thr_full(thr_full),
        .thr_data(thr_q), .take(take), .busy(tx_busy), .tx(tx_o)
    );

    sio_rx rx_i_u (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cfg(cfg), .rx_in(rx_i),
        .done(rx_done), .data(rx_data), .ferr(rx_ferr), .perr(rx_perr)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q       <= DIV_W'(1);
            line_q      <= '0;
            mask_q      <= '0;
            thr_q       <= '0;
            rbr_q       <= '0;
            thr_full    <= 1'b0;
            rx_full     <= 1'b0;
            ferr_q      <= 1'b0;
            perr_q      <= 1'b0;
            ovr_q       <= 1'b0;
            tx_ack_seen <= 1'b0;
            rx_ack_seen <= 1'b0;
        end else begin
            if (wr_div) div_q <= bus_wdata[DIV_W-1:0];
            if (bus_wr && bus_addr == A_LINE) line_q <= bus_wdata[5:0];
            if (bus_wr && bus_addr == A_MASK) mask_q <= bus_wdata[1:0];
            if (wr_txd) begin
                thr_q    <= bus_wdata[DMAX-1:0];
                thr_full <= 1'b1;
            end else if (take) begin
                thr_full <= 1'b0;
            end
            if (load) begin
                rbr_q   <= rx_data;
                rx_full <= 1'b1;
            end else if (pop) begin
                rx_full <= 1'b0;
            end
            if (wr_stat && bus_wdata[2]) ferr_q <= 1'b0;
            if (wr_stat && bus_wdata[3]) perr_q <= 1'b0;
            if (wr_stat && bus_wdata[4]) ovr_q  <= 1'b0;
            if (rx_done && rx_ferr) ferr_q <= 1'b1;
            if (rx_done && rx_perr) perr_q <= 1'b1;
            if (rx_done && rx_full && !pop) ovr_q <= 1'b1;
            if (txd_ack) tx_ack_seen <= 1'b1;
            if (take)    tx_ack_seen <= 1'b0;
            if (rxd_ack) rx_ack_seen <= 1'b1;
            if (load)    rx_ack_seen <= 1'b0;
        end
    end

    always_comb begin
        txd_req = line_q[5] && !thr_full && !tx_ack_seen;
        rxd_req = rx_full && !rx_ack_seen;
        irq_o   = (mask_q[0] && !thr_full) ||
                  (mask_q[1] && (rx_full || ferr_q || perr_q || ovr_q));
        unique case (bus_addr)
            A_DIV:   bus_rdata = 16'(div_q);
            A_LINE:  bus_rdata = {10'd0, line_q};
            A_STAT:  bus_rdata = {10'd0, tx_busy, ovr_q, perr_q, ferr_q, rx_full, !thr_full};
            A_MASK:  bus_rdata = {14'd0, mask_q};
            A_RXD:   bus_rdata = 16'(rbr_q);
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/sio_port_chk.sv
module sio_port_chk
    import sio_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        bus_wr,
    input logic        bus_rd,
    input logic [2:0]  bus_addr,
    input logic [15:0] bus_wdata,
    input logic        irq_o,
    input logic        txd_req,
    input logic        txd_ack,
    input logic        rxd_req,
    input logic        rxd_ack,
    input logic        thr_full,
    input logic        rx_full,
    input logic        ferr_q,
    input logic        ovr_q,
    input logic [1:0]  mask_q
);
    AST_TXREQ_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        txd_req |-> !thr_full);                                                     // R13
    AST_TXACK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (txd_ack && txd_req) |=> !txd_req);                                         // R13
    AST_RXREQ_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        rxd_req |-> rx_full);                                                       // R14
    AST_RXACK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (rxd_ack && rxd_req && !(bus_rd && bus_addr == A_RXD)) |=> !rxd_req);      // R14
    AST_FERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ferr_q && !(bus_wr && bus_addr == A_STAT && bus_wdata[2])) |=> ferr_q);   // R11
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_q && !(bus_wr && bus_addr == A_STAT && bus_wdata[4])) |=> ovr_q);     // R11
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == 2'b00) |-> !irq_o);                                              // R12
endmodule

bind sio_port sio_port_chk chk_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .irq_o(irq_o), .txd_req(txd_req), .txd_ack(txd_ack),
    .rxd_req(rxd_req), .rxd_ack(rxd_ack), .thr_full(thr_full), .rx_full(rx_full),
    .ferr_q(ferr_q), .ovr_q(ovr_q), .mask_q(mask_q)
);

// File: tb/sio_port_tb_top.sv
module sio_port_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        rx_i = 1'b1;
    logic        tx_o, irq_o, txd_req, rxd_req;
    logic        txd_ack = 1'b0, rxd_ack = 1'b0;

    int n_chk = 0, n_bad = 0, cyc = 0, div = 2;
    bit fr_q[$];
    logic [15:0] r;

    always #2 clk = ~clk;   // 4 ns period, 250 MHz

    sio_port dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_i(rx_i), .tx_o(tx_o),
        .irq_o(irq_o), .txd_req(txd_req), .txd_ack(txd_ack), .rxd_req(rxd_req), .rxd_ack(rxd_ack)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk); bus_addr = a; bus_rd = 1'b1; #1 d = bus_rdata;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    function automatic int eff_stop(input int n, input bit pe, input bit two);
        if (two) return 2;
        if (n + (pe ? 1 : 0) + 1 < 7) return 2;
        return 1;
    endfunction

    task automatic add_frame(input int d, input int n, input bit pe, input bit odd,
                             input int ns, input bit flip, input bit stopv);
        bit p = odd ^ flip;
        fr_q.push_back(1'b0);
        for (int i = 0; i < n; i++) begin
            fr_q.push_back(d[i]);
            p ^= d[i];
        end
        if (pe) fr_q.push_back(p);
        for (int i = 0; i < ns; i++) fr_q.push_back(stopv);
    endtask

    // Clock-by-clock comparison of tx_o against the expected bit stream.
    task automatic tx_check(input string tag);
        int w = 0, bad = 0, per = 16 * div;
        while (tx_o !== 1'b0 && w < 20000) begin @(negedge clk); w++; end
        for (int k = 0; k < fr_q.size() * per; k++) begin
            if (tx_o !== fr_q[k / per]) bad++;
            @(negedge clk);
        end
        chk(bad == 0, tag, bad, 0);
        chk(tx_o === 1'b1, {tag, " idle high"}, tx_o, 1);
        fr_q.delete();
    endtask

    task automatic rx_send();
        int per = 16 * div;
        for (int k = 0; k < fr_q.size(); k++) begin
            rx_i = fr_q[k];
            repeat (per) @(negedge clk);
        end
        rx_i = 1'b1;
        repeat (per) @(negedge clk);
        fr_q.delete();
    endtask

    task automatic wait_thr_empty();
        logic [15:0] s;
        s = 16'h0;
        for (int i = 0; i < 5000 && !s[0]; i++) rd(3'd2, s);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 195000) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(tx_o === 1'b1, "R1 tx idle", tx_o, 1);
        chk(irq_o === 1'b0 && txd_req === 1'b0 && rxd_req === 1'b0, "R1 outputs low",
            {irq_o, txd_req, rxd_req}, 0);
        rd(3'd2, r); chk(r == 16'h0001, "R1 status", r, 1);
        rd(3'd0, r); chk(r == 16'h0001, "R1 divisor", r, 1);

        // R2/R3: 8 data, no parity, 1 stop at divisor 2
        div = 2;
        wr(3'd0, 16'd2); wr(3'd1, 16'h0003); wr(3'd4, 16'h00A5);
        add_frame(8'hA5, 8, 0, 0, 1, 0, 1);
        tx_check("R3 R2 8N1 frame");

        // R4: 7 data, even parity, 2 stop
        wr(3'd1, 16'h0016); wr(3'd4, 16'h0053);
        add_frame(8'h53, 7, 1, 0, 2, 0, 1);
        tx_check("R4 even parity frame");

        // R4 + R2: 8 data, odd parity, divisor 3
        div = 3;
        wr(3'd0, 16'd3); wr(3'd1, 16'h000F); wr(3'd4, 16'h00C1);
        add_frame(8'hC1, 8, 1, 1, 1, 0, 1);
        tx_check("R4 odd parity frame");

        // R5: 5N1 clamped to two stops, back-to-back characters
        div = 2;
        wr(3'd0, 16'd2); wr(3'd1, 16'h0000); wr(3'd4, 16'h0015);
        add_frame(5'h15, 5, 0, 0, eff_stop(5, 0, 0), 0, 1);
        add_frame(5'h0A, 5, 0, 0, eff_stop(5, 0, 0), 0, 1);
        fork
            tx_check("R5 clamped back-to-back");
            begin wait_thr_empty(); wr(3'd4, 16'h000A); end
        join

        // R6: receive 8N1
        wr(3'd1, 16'h0003);
        add_frame(8'h3C, 8, 0, 0, 1, 0, 1); rx_send();
        rd(3'd2, r); chk(r[4:1] == 4'b0001, "R6 status full", r[4:1], 1);
        rd(3'd5, r); chk(r == 16'h003C, "R6 data", r, 16'h3C);
        rd(3'd2, r); chk(r[1] == 1'b0, "R6 full cleared", r[1], 0);

        // R7: glitch shorter than half a bit
        rx_i = 1'b0; repeat (4 * div) @(negedge clk); rx_i = 1'b1;
        repeat (64 * div) @(negedge clk);
        rd(3'd2, r); chk(r[4:1] == 4'b0000, "R7 glitch ignored", r[4:1], 0);
        wr(3'd1, 16'h0002);
        add_frame(7'h41, 7, 0, 0, 1, 0, 1); rx_send();
        rd(3'd5, r); chk(r == 16'h0041, "R7 R6 7-bit after glitch", r, 16'h41);

        // R8: parity mismatch (8 data, even)
        wr(3'd1, 16'h0007);
        add_frame(8'h96, 8, 1, 0, 1, 1, 1); rx_send();
        rd(3'd2, r); chk(r[3] == 1'b1 && r[2] == 1'b0, "R8 parity error", r[4:1], 4'b0101);
        rd(3'd5, r);
        rd(3'd2, r); chk(r[3] == 1'b1, "R11 perr kept after read", r[3], 1);
        wr(3'd2, 16'h0008);
        rd(3'd2, r); chk(r[3] == 1'b0, "R11 perr cleared", r[3], 0);

        // R9: low stop bit
        wr(3'd1, 16'h0003);
        add_frame(8'h5A, 8, 0, 0, 1, 0, 0); rx_send();
        repeat (48 * div) @(negedge clk);
        rd(3'd2, r); chk(r[2] == 1'b1, "R9 framing error", r[2], 1);
        rd(3'd5, r);
        wr(3'd2, 16'h0004);
        rd(3'd2, r); chk(r[4:1] == 4'b0000, "R11 ferr cleared", r[4:1], 0);

        // R10: overrun keeps the first character
        add_frame(8'h11, 8, 0, 0, 1, 0, 1); add_frame(8'h22, 8, 0, 0, 1, 0, 1); rx_send();
        rd(3'd2, r); chk(r[4] == 1'b1, "R10 overrun", r[4], 1);
        rd(3'd5, r); chk(r == 16'h0011, "R10 first kept", r, 16'h11);
        wr(3'd2, 16'h0010);
        rd(3'd2, r); chk(r[4] == 1'b0, "R11 ovr cleared", r[4], 0);

        // R12: interrupt masking
        wr(3'd3, 16'h0000); @(negedge clk);
        chk(irq_o === 1'b0, "R12 mask 0", irq_o, 0);
        wr(3'd3, 16'h0001); @(negedge clk);
        chk(irq_o === 1'b1, "R12 tx empty irq", irq_o, 1);
        wr(3'd3, 16'h0002); @(negedge clk);
        chk(irq_o === 1'b0, "R12 rx idle no irq", irq_o, 0);
        add_frame(8'h77, 8, 0, 0, 1, 0, 1); rx_send();
        chk(irq_o === 1'b1, "R12 rx irq", irq_o, 1);
        rd(3'd5, r); @(negedge clk);
        chk(irq_o === 1'b0, "R12 rx irq cleared", irq_o, 0);
        wr(3'd3, 16'h0000);

        // R13: transmit DMA handshake
        wr(3'd1, 16'h0023); @(negedge clk);
        chk(txd_req === 1'b1, "R13 req when empty", txd_req, 1);
        txd_ack = 1'b1; @(negedge clk); txd_ack = 1'b0;
        chk(txd_req === 1'b0, "R13 drop on ack", txd_req, 0);
        wr(3'd4, 16'h0033);
        chk(txd_req === 1'b0, "R13 low while full", txd_req, 0);
        wait_thr_empty(); @(negedge clk);
        chk(txd_req === 1'b1, "R13 rearm after take", txd_req, 1);
        wr(3'd1, 16'h0003);
        repeat (12 * 16 * div) @(negedge clk);

        // R14: receive DMA handshake
        add_frame(8'h6E, 8, 0, 0, 1, 0, 1); rx_send();
        chk(rxd_req === 1'b1, "R14 req when full", rxd_req, 1);
        rxd_ack = 1'b1; @(negedge clk); rxd_ack = 1'b0;
        chk(rxd_req === 1'b0, "R14 drop on ack", rxd_req, 0);
        rd(3'd5, r); chk(r == 16'h006E, "R14 data", r, 16'h6E);
        add_frame(8'h19, 8, 0, 0, 1, 0, 1); rx_send();
        chk(rxd_req === 1'b1, "R14 rearm", rxd_req, 1);
        rd(3'd5, r);

        // R2: divisor 0 means 65,536 clocks per strobe
        wr(3'd0, 16'd0); wr(3'd4, 16'h0000);
        repeat (60000) @(negedge clk);
        chk(tx_o === 1'b1, "R2 div0 before first strobe", tx_o, 1);
        repeat (10000) @(negedge clk);
        chk(tx_o === 1'b0, "R2 div0 start bit", tx_o, 0);
        repeat (60000) @(negedge clk);
        chk(tx_o === 1'b0, "R2 div0 long start bit", tx_o, 0);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule